// File: doc/BRIEF.md
# PLL Fast Lock Timer

This block controls how long a frequency synthesizer loop stays in its wide-bandwidth state after a new output frequency has been programmed. A control word supplies a 2-bit mode code, a 12-bit timer value and the fractional modulus. The block runs on the phase-detector-rate clock. When a "new frequency loaded" strobe arrives and fast lock is armed, the block raises a wide-bandwidth flag. It holds the flag for the timer value multiplied by the modulus in clock cycles, then drops it so the loop settles at its narrow final bandwidth.

Choose the programmed interval so that it covers both the oscillator band-selection time and the lock time in the wide state. For example, a timer value of 8 with a modulus of 65 at a 13 MHz comparison rate gives 520 cycles, which is 40 µs. When the interval ends, the block issues a one-cycle done pulse.

Top module: `pll_fastlock_timer`

## Requirements
- R1: After reset, `wide_bw` and `done` are low, and the stored mode is 2'b00 (fast lock off).
- R2: A `freq_load` strobe, taken while the stored mode is 2'b01 and the stored timer value is nonzero, makes `wide_bw` high in the cycle after the clock edge that samples the strobe.
- R3: `wide_bw` stays high for exactly timer value × modulus cycles. A stored modulus of 0 behaves as 1.
- R4: `done` is high for exactly one cycle. That cycle is the first cycle in which `wide_bw` is low again after an interval that ran to its end.
- R5: While the stored mode is 2'b00, 2'b10 or 2'b11, strobes are ignored, and `wide_bw` and `done` stay low.
- R6: Writing a mode other than 2'b01 while an interval runs makes `wide_bw` low from the cycle after the write edge, with no `done` pulse.
- R7: A strobe during a running interval restarts it. `wide_bw` then stays high for the full timer value × modulus cycles counted from the new strobe.
- R8: A strobe taken with a stored timer value of 0 produces no interval and no `done`. If an interval is running, such a strobe ends it without a `done` pulse.
- R9: Control words written during an interval (`cfg_wr` high, fields `cfg_mode`, `cfg_timer`, `cfg_mod` captured at that edge) do not change the length of that interval when the mode stays 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase-detector-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| cfg_wr | input | 1 | Captures the three control fields at this edge |
| cfg_mode | input | 2 | Mode code; 2'b01 arms fast lock |
| cfg_timer | input | 12 | Timer value, counted in modulus units |
| cfg_mod | input | 12 | Fractional modulus (0 treated as 1) |
| freq_load | input | 1 | New-frequency strobe that starts or restarts the interval |
| wide_bw | output | 1 | High while the loop must stay in its wide state |
| done | output | 1 | One-cycle pulse at the end of a completed interval |

## Verification
Random control words, with mode codes biased toward 2'b01, with timer values that include 0 and with moduli that include 0 and 1, check that the product rule holds. They also check that prescaler and down-counter lengths cannot be traded for each other. Directed cases place a second strobe inside a running interval, which tells a true restart apart from a continued count. A mid-run mode change tells an abort apart from normal expiry by the absence of `done`. A mid-run rewrite of the timer value and modulus separates values snapshotted at the start from fields read live. A zero-value strobe during a run confirms that it cancels the interval without a completion pulse.

// File: rtl/flt_pkg.sv
package flt_pkg;
  typedef enum logic [1:0] {
    FL_MODE_OFF  = 2'b00,
    FL_MODE_FAST = 2'b01,
    FL_MODE_RSV2 = 2'b10,
    FL_MODE_RSV3 = 2'b11
  } fl_mode_e;

  localparam int unsigned FL_TIMER_W = 12;
  localparam int unsigned FL_MOD_W   = 12;
endpackage

// File: rtl/flt_cfg_regs.sv
module flt_cfg_regs
  import flt_pkg::*;
#(
  parameter int unsigned TIMER_W = FL_TIMER_W,
  parameter int unsigned MOD_W   = FL_MOD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         mode_in,
  input  logic [TIMER_W-1:0] timer_in,
  input  logic [MOD_W-1:0]   mod_in,
  output fl_mode_e           mode_q,
  output logic [TIMER_W-1:0] timer_q,
  output logic [MOD_W-1:0]   mod_q
);
  fl_mode_e           mode_d;
  logic [TIMER_W-1:0] timer_d;
  logic [MOD_W-1:0]   mod_d;

  always_comb begin
    mode_d  = mode_q;
    timer_d = timer_q;
    mod_d   = mod_q;
    if (wr_en) begin
      mode_d  = fl_mode_e'(mode_in);
      timer_d = timer_in;
      mod_d   = mod_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= FL_MODE_OFF;
      timer_q <= '0;
      mod_q   <= '0;
    end else begin
      mode_q  <= mode_d;
      timer_q <= timer_d;
      mod_q   <= mod_d;
    end
  end
endmodule

// File: rtl/flt_prescaler.sv
module flt_prescaler
  import flt_pkg::*;
#(
  parameter int unsigned MOD_W = FL_MOD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [MOD_W-1:0] mod_in,
  output logic             tick
);
  localparam int unsigned CW = MOD_W + 1;

  logic [MOD_W-1:0] cnt_q, cnt_d;
  logic [MOD_W-1:0] snap_q, snap_d;
  logic [CW-1:0]    cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + CW'(1);
  assign tick    = run && !restart && (cnt_inc >= {1'b0, snap_q});

  always_comb begin
    snap_d = snap_q;
    cnt_d  = cnt_q;
    if (restart) begin
      snap_d = mod_in;
      cnt_d  = '0;
    end else if (!run) begin
      cnt_d  = '0;
    end else if (tick) begin
      cnt_d  = '0;
    end else begin
      cnt_d  = cnt_inc[MOD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      snap_q <= snap_d;
    end
  end
endmodule

// File: rtl/flt_downcount.sv
module flt_downcount
  import flt_pkg::*;
#(
  parameter int unsigned W = FL_TIMER_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         busy,
  output logic         last_tick
);
  logic [W-1:0] cnt_q, cnt_d;

  assign busy      = (cnt_q != '0);
  assign last_tick = tick && (cnt_q == W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (clear)                  cnt_d = '0;
    else if (load)              cnt_d = load_val;
    else if (tick && busy)      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pll_fastlock_timer.sv
module pll_fastlock_timer
  import flt_pkg::*;
#(
  parameter int unsigned TIMER_W = FL_TIMER_W,
  parameter int unsigned MOD_W   = FL_MOD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [1:0]         cfg_mode,
  input  logic [TIMER_W-1:0] cfg_timer,
  input  logic [MOD_W-1:0]   cfg_mod,
  input  logic               freq_load,
  output logic               wide_bw,
  output logic               done
);
  fl_mode_e           mode_q;
  logic [TIMER_W-1:0] timer_q;
  logic [MOD_W-1:0]   mod_q;
  logic               armed, accept, tick, busy, last_tick;
  logic               done_q, done_d;

  flt_cfg_regs #(.TIMER_W(TIMER_W), .MOD_W(MOD_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr),
    .mode_in(cfg_mode), .timer_in(cfg_timer), .mod_in(cfg_mod),
    .mode_q(mode_q), .timer_q(timer_q), .mod_q(mod_q)
  );

  assign armed  = (mode_q == FL_MODE_FAST);
  assign accept = freq_load && armed;

  flt_prescaler #(.MOD_W(MOD_W)) u_presc (
    .clk(clk), .rst_n(rst_n),
    .run(armed && busy), .restart(accept),
    .mod_in(mod_q), .tick(tick)
  );

  flt_downcount #(.W(TIMER_W)) u_down (
    .clk(clk), .rst_n(rst_n),
    .clear(!armed), .load(accept), .load_val(timer_q),
    .tick(tick), .busy(busy), .last_tick(last_tick)
  );

  assign done_d = last_tick && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign wide_bw = busy && armed;
  assign done    = done_q;
endmodule

// File: rtl/flt_checker.sv
module flt_checker #(
  parameter int unsigned TIMER_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               freq_load,
  input logic               armed,
  input logic [TIMER_W-1:0] timer_q,
  input logic               wide_bw,
  input logic               done
);
  AST_START_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_load && armed && timer_q != '0) |=> wide_bw); // R2
  AST_DONE_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!wide_bw && $past(wide_bw))); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_IDLE_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !$past(armed)) |-> (!wide_bw && !done)); // R5
  AST_ZERO_NO_INTERVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_load && armed && timer_q == '0) |=> (!wide_bw && !done)); // R8
endmodule

bind pll_fastlock_timer flt_checker #(.TIMER_W(TIMER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .freq_load(freq_load), .armed(armed),
  .timer_q(timer_q), .wide_bw(wide_bw), .done(done)
);

// File: tb/tb_pll_fastlock_timer.sv
`timescale 1ns/1ps
module tb_pll_fastlock_timer;
  logic        clk, rst_n, cfg_wr, freq_load;
  logic [1:0]  cfg_mode;
  logic [11:0] cfg_timer, cfg_mod;
  logic        wide_bw, done;
  int tests = 0;
  int fails = 0;

  pll_fastlock_timer dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_timer(cfg_timer), .cfg_mod(cfg_mod), .freq_load(freq_load),
    .wide_bw(wide_bw), .done(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int exp_len(int mode, int t, int m);
    if (mode != 1) return 0;
    return t * ((m == 0) ? 1 : m);
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge; consumes one cycle
  task automatic write_cfg(int mode, int t, int m);
    cfg_wr = 1'b1; cfg_mode = 2'(mode); cfg_timer = 12'(t); cfg_mod = 12'(m);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic fire();
    freq_load = 1'b1;
    @(negedge clk);
    freq_load = 1'b0;
  endtask

  task automatic measure_tail(string req, int exp);
    int len = 0;
    int dones = 0;
    int at_fall = 0;
    while (wide_bw && len < 100000) begin
      if (done) dones++;
      len++;
      @(negedge clk);
    end
    if (done) begin at_fall = 1; dones++; end
    @(negedge clk);
    if (done) dones++;
    check({req, " length"}, len, exp);
    check({req, " done count"}, dones, (exp > 0) ? 1 : 0);
    if (exp > 0) check({req, " done at fall"}, at_fall, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_mode = 2'b00; cfg_timer = '0;
    cfg_mod = '0; freq_load = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 wide_bw after reset", int'(wide_bw), 0);
    check("R1 done after reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 default mode off: strobe ignored
    fire();
    measure_tail("R5 strobe in reset mode", 0);

    // R2 R3 example value 8 x 65
    write_cfg(1, 8, 65);
    fire();
    check("R2 flag after strobe", int'(wide_bw), 1);
    measure_tail("R3 example 8x65", 520);

    // R3 modulus 0 acts as 1
    write_cfg(1, 7, 0);
    fire();
    measure_tail("R3 modulus zero", 7);

    // R5 other mode codes
    for (int md = 0; md < 4; md++) begin
      if (md == 1) continue;
      write_cfg(md, 5, 3);
      fire();
      measure_tail("R5 non-arming mode", 0);
    end

    // R8 zero timer
    write_cfg(1, 0, 9);
    fire();
    measure_tail("R8 zero timer", 0);

    // R7 restart mid-run
    write_cfg(1, 4, 6);
    fire();
    repeat (9) @(negedge clk);
    fire();
    measure_tail("R7 restart", 24);

    // R6 mode change mid-run
    write_cfg(1, 6, 5);
    fire();
    repeat (4) @(negedge clk);
    write_cfg(0, 6, 5);
    check("R6 flag low after mode write", int'(wide_bw), 0);
    check("R6 no done on abort", int'(done), 0);
    @(negedge clk);
    check("R6 no done later", int'(done), 0);

    // R9 rewrite during run does not alter interval
    write_cfg(1, 4, 5);
    fire();
    write_cfg(1, 9, 2);
    measure_tail("R9 rewrite mid-run", 19);
    fire();
    measure_tail("R9 new values next run", 18);

    // R8 zero-value strobe ends running interval
    write_cfg(1, 6, 4);
    fire();
    repeat (2) @(negedge clk);
    write_cfg(1, 0, 4);
    fire();
    measure_tail("R8 zero strobe aborts", 0);

    // random trials, R3 R4 R5
    for (int i = 0; i < 25; i++) begin
      int md = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 3)) : 1;
      int t  = int'($urandom_range(0, 15));
      int m  = int'($urandom_range(0, 30));
      write_cfg(md, t, m);
      fire();
      measure_tail("R3 R4 random", exp_len(md, t, m));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule